// File: doc/BRIEF.md
# Serial Channel-Update Transmitter

This block sits on the host side of a three-wire serial link to a bank of twelve (up to sixteen) 8-bit output channels. A single request carries a 4-bit channel address and an 8-bit value. The transmitter lowers chip select and shifts the address and then the value out on a data line, most significant bit first. The serial clock idles high, and data changes only while the clock is low. Raising chip select at the end makes the receiver commit the value to the addressed channel. Each channel update takes one full chip-select window.

Two frame layouts are offered. The compact layout sends exactly twelve bits. The byte-aligned layout sends sixteen bits by putting four filler bits ahead of the address, which suits receivers and hosts that work in whole bytes. Every interface interval is a parameter counted in system clock cycles, so the serial timing can be fitted to any minimum limits: clock half-period, chip-select setup, the hold from the last rising edge to chip-select release, and the chip-select high time between frames. The block reports busy while a frame is in flight and gives a one-cycle done pulse when the update is complete.

Top module: `dactx_tx`

## Requirements
- R1: While reset is held, and in the first cycle after it, csN and sclk are 1 and busy and done are 0.
- R2: With reqWide=0 an accepted request produces exactly 12 rising sclk edges inside one csN-low window: the 4 address bits, most significant first, then the 8 value bits, most significant first.
- R3: With reqWide=1 the window holds exactly 16 rising edges: four filler bits driven as 0, then the address bits, then the value bits, each field most significant first.
- R4: sclk is 1 in every cycle in which csN falls or rises, so the serial clock is high at the start and at the end of each transfer.
- R5: sdo does not change while sclk stays high inside a csN-low window; it changes only together with a falling sclk.
- R6: Each sclk low phase and each sclk high phase inside a window lasts exactly HALF_CYC cycles, and csN is low for exactly CS_SETUP cycles before the first falling sclk edge.
- R7: csN rises exactly HALF_CYC+CS_HOLD cycles after the last rising sclk edge, and done comes only after csN has been high for exactly CS_GAP cycles.
- R8: busy is 1 from the cycle after acceptance until done; reqValid is ignored while busy, so no extra frame appears.
- R9: done is a single-cycle pulse, given once per accepted request, in a cycle where busy is already 0.
- R10: A request presented in the cycle done is high is accepted, and it starts a new, separate chip-select window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, taken only when idle |
| reqWide | input | 1 | 1 selects the 16-bit byte-aligned frame, 0 the 12-bit frame |
| reqAddr | input | 4 | Channel address of the update |
| reqData | input | 8 | Value for the channel |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse when the update is committed and the gap has elapsed |
| csN | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles high |
| sdo | output | 1 | Serial data, valid at the rising sclk edge |

## Verification
The done pulse and the acceptance of the next request can fall in the same cycle, because done is raised as the sequencer returns to idle. The bench provokes this by waiting for the done sample and driving a new request at that moment. It then checks that busy rises on the following cycle, that the new chip-select window is decoded as its own frame carrying the right address and value, and that the chip-select high interval before done still matches the configured gap.

// File: rtl/dactx_pkg.sv
package dactx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_HOLD,
    ST_GAP
  } txState_t;

  typedef struct packed {
    logic load;
    logic shift;
  } dpCtl_t;

endpackage

// File: rtl/dactx_shifter.sv
module dactx_shifter
  import dactx_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int PAD_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              reqWide,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              sdo,
  output logic              lastBit
);

  localparam int NARROW_W = ADDR_W + DATA_W;
  localparam int FRAME_W  = PAD_W + NARROW_W;
  localparam int CNT_W    = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] shiftReg;
  logic [CNT_W-1:0]   bitsLeft;
  logic [FRAME_W-1:0] wideImage;
  logic [FRAME_W-1:0] narrowImage;

  // Both layouts are left-justified so the first bit to send is always the top bit.
  generate
    if (PAD_W > 0) begin : g_pad
      assign wideImage   = {{PAD_W{1'b0}}, reqAddr, reqData};
      assign narrowImage = {reqAddr, reqData, {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign wideImage   = {reqAddr, reqData};
      assign narrowImage = {reqAddr, reqData};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitsLeft <= '0;
    end else if (ctl.load) begin
      shiftReg <= reqWide ? wideImage : narrowImage;
      bitsLeft <= reqWide ? CNT_W'(FRAME_W - 1) : CNT_W'(NARROW_W - 1);
    end else if (ctl.shift) begin
      shiftReg <= {shiftReg[FRAME_W-2:0], 1'b0};
      bitsLeft <= bitsLeft - 1'b1;
    end
  end

  assign sdo     = shiftReg[FRAME_W-1];
  assign lastBit = (bitsLeft == '0);

endmodule

// File: rtl/dactx_sequencer.sv
module dactx_sequencer
  import dactx_pkg::*;
#(
  parameter int HALF_CYC = 2,
  parameter int CS_SETUP = 2,
  parameter int CS_HOLD  = 2,
  parameter int CS_GAP   = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   lastBit,
  output dpCtl_t ctl,
  output logic   csN,
  output logic   sclk,
  output logic   busy,
  output logic   done
);

  localparam int MAX_AB   = (HALF_CYC > CS_SETUP) ? HALF_CYC : CS_SETUP;
  localparam int MAX_CD   = (CS_HOLD > CS_GAP) ? CS_HOLD : CS_GAP;
  localparam int MAX_WAIT = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int TMR_W    = (MAX_WAIT > 1) ? $clog2(MAX_WAIT) : 1;

  localparam logic [TMR_W-1:0] T_HALF  = TMR_W'(HALF_CYC - 1);
  localparam logic [TMR_W-1:0] T_SETUP = TMR_W'(CS_SETUP - 1);
  localparam logic [TMR_W-1:0] T_HOLD  = TMR_W'(CS_HOLD - 1);
  localparam logic [TMR_W-1:0] T_GAP   = TMR_W'(CS_GAP - 1);

  txState_t         state, nextState;
  logic [TMR_W-1:0] tmr, nextTmr;
  logic             nextDone;
  logic             expired;

  assign expired = (tmr == '0);

  always_comb begin
    nextState = state;
    nextTmr   = expired ? tmr : tmr - 1'b1;
    nextDone  = 1'b0;
    ctl       = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.load  = 1'b1;
          nextState = ST_SETUP;
          nextTmr   = T_SETUP;
        end
      end
      ST_SETUP: begin
        if (expired) begin
          nextState = ST_LOW;
          nextTmr   = T_HALF;
        end
      end
      ST_LOW: begin
        if (expired) begin
          nextState = ST_HIGH;
          nextTmr   = T_HALF;
        end
      end
      ST_HIGH: begin
        if (expired) begin
          if (lastBit) begin
            nextState = ST_HOLD;
            nextTmr   = T_HOLD;
          end else begin
            ctl.shift = 1'b1;
            nextState = ST_LOW;
            nextTmr   = T_HALF;
          end
        end
      end
      ST_HOLD: begin
        if (expired) begin
          nextState = ST_GAP;
          nextTmr   = T_GAP;
        end
      end
      ST_GAP: begin
        if (expired) begin
          nextState = ST_IDLE;
          nextDone  = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      tmr   <= '0;
      done  <= 1'b0;
    end else begin
      state <= nextState;
      tmr   <= nextTmr;
      done  <= nextDone;
    end
  end

  assign csN  = (state == ST_IDLE) || (state == ST_GAP);
  assign sclk = (state != ST_LOW);
  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/dactx_tx.sv
module dactx_tx
  import dactx_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int PAD_W    = 4,
  parameter int HALF_CYC = 2,
  parameter int CS_SETUP = 2,
  parameter int CS_HOLD  = 2,
  parameter int CS_GAP   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWide,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              busy,
  output logic              done,
  output logic              csN,
  output logic              sclk,
  output logic              sdo
);

  dpCtl_t ctl;
  logic   lastBit;

  dactx_sequencer #(
    .HALF_CYC(HALF_CYC),
    .CS_SETUP(CS_SETUP),
    .CS_HOLD (CS_HOLD),
    .CS_GAP  (CS_GAP)
  ) u_seq (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .lastBit (lastBit),
    .ctl     (ctl),
    .csN     (csN),
    .sclk    (sclk),
    .busy    (busy),
    .done    (done)
  );

  dactx_shifter #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .PAD_W (PAD_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .reqWide(reqWide),
    .reqAddr(reqAddr),
    .reqData(reqData),
    .sdo    (sdo),
    .lastBit(lastBit)
  );

endmodule

// File: rtl/dactx_checks.sv
module dactx_checks #(
  parameter int HALF_CYC = 2
) (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic sclk,
  input logic sdo,
  input logic busy,
  input logic done
);

  logic [15:0] lowRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lowRun <= '0;
    else if (!sclk) lowRun <= lowRun + 1'b1;
    else lowRun <= '0;
  end

  // R4
  cs_edge_clk_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(csN) || $fell(csN)) |-> sclk);

  // R5
  data_stable_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && $past(!csN) && sclk && $past(sclk)) |-> $stable(sdo));

  // R6
  low_phase_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && lowRun != 0) |-> (lowRun == 16'(HALF_CYC)));

  // R8
  busy_in_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> busy);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

bind dactx_tx dactx_checks #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk (clk),
  .rstN(rstN),
  .csN (csN),
  .sclk(sclk),
  .sdo (sdo),
  .busy(busy),
  .done(done)
);

// File: tb/dactx_tx_test.sv
module dactx_tx_test;

  localparam int CLK_PERIOD = 10;
  localparam int HALF  = 3;
  localparam int SETUP = 2;
  localparam int HOLD  = 2;
  localparam int GAP   = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqWide = 1'b0;
  logic [3:0] reqAddr = '0;
  logic [7:0] reqData = '0;
  logic       busy, done, csN, sclk, sdo;

  dactx_tx #(
    .HALF_CYC(HALF), .CS_SETUP(SETUP), .CS_HOLD(HOLD), .CS_GAP(GAP)
  ) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWide(reqWide),
    .reqAddr(reqAddr), .reqData(reqData), .busy(busy), .done(done),
    .csN(csN), .sclk(sclk), .sdo(sdo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0;
  int fails = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct { bit wide; int a; int d; } item_t;
  item_t expQ[$];

  // Behavioural receiver and scoreboard monitor
  logic [15:0] rxShift = '0;
  int rxBits = 0;
  int framesSeen = 0;

  always @(negedge csN) begin
    rxShift = '0;
    rxBits = 0;
  end

  always @(posedge sclk) begin
    if (csN === 1'b0) begin
      rxShift = {rxShift[14:0], sdo};
      rxBits++;
    end
  end

  always @(posedge csN) begin
    if (rstN === 1'b1) begin
      framesSeen++;
      if (expQ.size() == 0) begin
        check(1'b0, "R8 frame without accepted request", framesSeen, 0);
      end else begin
        item_t it;
        it = expQ.pop_front();
        if (it.wide) begin
          check(rxBits == 16, "R3 bit count", rxBits, 16);
          check(rxShift[15:12] == 4'h0, "R3 filler bits", rxShift[15:12], 0);
          check(rxShift[11:8] == it.a[3:0], "R3 address", rxShift[11:8], it.a);
          check(rxShift[7:0] == it.d[7:0], "R3 value", rxShift[7:0], it.d);
        end else begin
          check(rxBits == 12, "R2 bit count", rxBits, 12);
          check(rxShift[11:8] == it.a[3:0], "R2 address", rxShift[11:8], it.a);
          check(rxShift[7:0] == it.d[7:0], "R2 value", rxShift[7:0], it.d);
        end
      end
    end
  end

  // Cycle-level timing monitor, sampled away from the active edge
  bit prevSclk = 1'b1, prevCs = 1'b1, prevDone = 1'b0, firstFall = 1'b0;
  int lowRun = 0, highRun = 0, csLowRun = 0, csHighRun = 0, riseAge = 0;
  int doneCount = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (prevSclk && !sclk) begin
        if (firstFall) check(csLowRun == SETUP, "R6 cs setup", csLowRun, SETUP);
        else check(highRun == HALF, "R6 high phase", highRun, HALF);
        firstFall = 1'b0;
      end
      if (!prevSclk && sclk) check(lowRun == HALF, "R6 low phase", lowRun, HALF);
      if (prevCs && !csN) begin
        firstFall = 1'b1;
        check(sclk == 1'b1, "R4 clock high at cs fall", sclk, 1);
      end
      if (!prevCs && csN) begin
        check(sclk == 1'b1, "R4 clock high at cs rise", sclk, 1);
        check(riseAge == HALF + HOLD - 1, "R7 last edge to cs rise", riseAge, HALF + HOLD - 1);
      end
      if (sclk && prevSclk && !csN && !prevCs && firstFall == 1'b0) begin
        // R5 is covered by the checker; sdo sampling edge handled in receiver
      end
      if (!csN) check(busy == 1'b1, "R8 busy in window", busy, 1);
      if (done) begin
        doneCount++;
        check(csHighRun == GAP, "R7 cs high before done", csHighRun, GAP);
        check(!prevDone, "R9 done single cycle", prevDone, 0);
        check(busy == 1'b0, "R9 idle at done", busy, 0);
      end
      lowRun    = sclk ? 0 : lowRun + 1;
      highRun   = sclk ? highRun + 1 : 0;
      csLowRun  = csN ? 0 : csLowRun + 1;
      csHighRun = csN ? csHighRun + 1 : 0;
      riseAge   = (!prevSclk && sclk) ? 0 : riseAge + 1;
      prevSclk  = sclk;
      prevCs    = csN;
      prevDone  = done;
    end
  end

  // Driver
  task automatic send(input bit wide, input int a, input int d);
    item_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    it.wide = wide; it.a = a; it.d = d;
    expQ.push_back(it);
    reqValid = 1'b1; reqWide = wide; reqAddr = 4'(a); reqData = 8'(d);
    @(negedge clk);
    reqValid = 1'b0;
    check(busy == 1'b1, "R8 busy after accept", busy, 1);
  endtask

  task automatic waitDone();
    @(negedge clk);
    while (!done) @(negedge clk);
  endtask

  task automatic sendAtDone(input bit wide, input int a, input int d);
    item_t it;
    waitDone();
    it.wide = wide; it.a = a; it.d = d;
    expQ.push_back(it);
    reqValid = 1'b1; reqWide = wide; reqAddr = 4'(a); reqData = 8'(d);
    @(negedge clk);
    reqValid = 1'b0;
    check(busy == 1'b1, "R10 accepted in done cycle", busy, 1);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    check(1'b0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int framesBefore;
    repeat (3) @(negedge clk);
    check(csN == 1'b1 && sclk == 1'b1, "R1 lines idle in reset", {csN, sclk}, 3);
    check(busy == 1'b0 && done == 1'b0, "R1 status clear in reset", {busy, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(csN == 1'b1 && sclk == 1'b1 && busy == 1'b0 && done == 1'b0,
          "R1 idle after reset", {csN, sclk, busy, done}, 12);

    // R2 compact frames
    send(1'b0, 0, 8'h00);
    send(1'b0, 11, 8'hFF);
    send(1'b0, 5, 8'hA5);
    send(1'b0, 15, 8'h3C);

    // R3 byte-aligned frames
    send(1'b1, 1, 8'h5A);
    send(1'b1, 10, 8'h80);
    send(1'b1, 15, 8'h01);

    // R8 requests while busy must be ignored
    waitDone();
    framesBefore = framesSeen;
    send(1'b0, 6, 8'h96);
    reqValid = 1'b1; reqWide = 1'b1; reqAddr = 4'h9; reqData = 8'h11;
    repeat (5) @(negedge clk);
    reqValid = 1'b0;
    waitDone();
    repeat (10) @(negedge clk);
    check(framesSeen == framesBefore + 1, "R8 one frame for one accept", framesSeen, framesBefore + 1);
    check(csN == 1'b1 && busy == 1'b0, "R8 no frame from busy request", {csN, busy}, 2);

    // R10 back-to-back at the done cycle, both layouts
    send(1'b0, 3, 8'h7E);
    sendAtDone(1'b1, 12, 8'hC3);
    sendAtDone(1'b0, 7, 8'h81);

    waitDone();
    repeat (10) @(negedge clk);
    check(expQ.size() == 0, "R2 all requests decoded", expQ.size(), 0);
    check(doneCount == framesSeen, "R9 one done per frame", doneCount, framesSeen);
    check(framesSeen == 11, "R9 frame total", framesSeen, 11);
    summary();
    $finish;
  end

endmodule